// File: doc/BRIEF.md
# Configurable Interrupt Status Controller

This block sits beside a video decoder core and turns its one-cycle event pulses into sticky status bits. Those bits drive a single interrupt request pad. Four event sources are tracked: lock gained, lock lost, free-run status change, and copy-protection detection. The copy-protection event counts only when its sub-type flags, pseudo-sync and color-stripe, match a selector in the configuration register.

Software uses a small synchronous register port, with byte-wide data and combinational read-back, to reach four registers:

- a configuration register at 0x40;
- a read-only status register at 0x42;
- a write-only clear register at 0x43;
- a mask register at 0x44.

The configuration register picks three things:

- **Pad style:** open drain, active low or active high.
- **Assertion length:** a fixed pulse of 3, 15 or 63 clock periods, or held until the request condition goes away.
- **Manual force:** a bit that raises the request regardless of events.

Top module: `vid_irq_ctrl`

## Requirements
- R1: After reset, the configuration, mask and status registers all read 0x00, and the pad is released (irq_oe = 0, irq_o = 0).
- R2: The status register at 0x42 has these bits: bit 0 = lock gained, bit 1 = lock lost, bit 2 = free-run change, bit 3 = copy protection. Each bit becomes 1 on the clock edge that samples its event and stays 1 until cleared. Bits 7:4 read 0.
- R3: Configuration bits 5:4 select which copy-protection sub-type sets status bit 3: 01 = pseudo-sync only, 10 = color-stripe only, 11 = either, 00 = neither.
- R4: Writing 1 to bit n (n = 0..3) of the clear register at 0x43 clears status bit n. Writing 0 leaves a bit unchanged. Bits 7:4 of the clear register are ignored. The clear register reads 0x00.
- R5: When an event and a clear for the same status bit land in the same cycle, the bit ends up set.
- R6: Mask register bit n (0x44, bits 3:0) set to 1 keeps status bit n out of the request condition. The status bit itself is still recorded.
- R7: Configuration bits 7:6 set the length select. With 00, 01 or 10, a rising request condition produces an active pulse of exactly 3, 15 or 63 clock cycles. The pulse begins one cycle after the status bit becomes visible.
- R8: With length select 11, the output is active exactly while the request condition holds. The request condition is the OR of unmasked set status bits and the manual force.
- R9: In fixed-length modes, an unmasked event that arrives during a pulse restarts the count.
- R10: Configuration bits 1:0 set the pad style:
  - 00: irq_oe equals active and irq_o is 0.
  - 01: irq_oe is 1 and irq_o is the inverse of active.
  - 10: irq_oe is 1 and irq_o equals active.
  - 11: irq_oe is 0 and irq_o is 0.
- R11: Configuration bit 2 set to 1 forces the request condition true regardless of status.
- R12: Configuration bit 3 is reserved and reads 0. Mask bits 7:4 read 0. Any unmapped address, including 0x41, reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| ev_lock | input | 1 | Decoder went from unlocked to locked |
| ev_unlock | input | 1 | Decoder went from locked to unlocked |
| ev_freerun | input | 1 | Free-run status changed |
| ev_cp | input | 1 | Copy-protection detection pulse |
| cp_pseudo | input | 1 | Detection was pseudo-sync type |
| cp_stripe | input | 1 | Detection was color-stripe type |
| irq_o | output | 1 | Interrupt pad data |
| irq_oe | output | 1 | Interrupt pad output enable |

## Verification
The copy-protection qualifier is exercised with a table that pairs every selector value with pseudo-sync-only, color-stripe-only and no-flag pulses. This separates the sub-type decode from plain event capture. Pulse length is measured for each fixed length select, with one pulse retriggered mid-flight. A lost restart or an off-by-one counter load therefore shows up as a wrong cycle count. Every pad style is checked with the request both active and idle, which separates polarity errors from output-enable errors. Same-cycle event and clear, masked events, and reserved clear bits cover the cases where a careless write would drop or invent an interrupt.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;

  localparam int NUM_SRC = 4;
  localparam int SRC_LOCK = 0;
  localparam int SRC_UNLOCK = 1;
  localparam int SRC_FREERUN = 2;
  localparam int SRC_CP = 3;

  typedef enum logic [1:0] {
    DRV_OPEN = 2'b00,
    DRV_LOW  = 2'b01,
    DRV_HIGH = 2'b10,
    DRV_NONE = 2'b11
  } drv_e;

  typedef enum logic [1:0] {
    LEN_SHORT = 2'b00,
    LEN_MID   = 2'b01,
    LEN_LONG  = 2'b10,
    LEN_HOLD  = 2'b11
  } len_e;

  typedef struct packed {
    len_e       len;
    logic [1:0] cp_sel;
    logic       rsvd;
    logic       manual;
    drv_e       drive;
  } cfg_t;

  // Which copy-protection sub-type counts for the selected mode
  function automatic logic cp_qualify(input logic [1:0] sel, input logic pseudo,
                                      input logic stripe);
    case (sel)
      2'b01:   return pseudo;
      2'b10:   return stripe;
      2'b11:   return pseudo | stripe;
      default: return 1'b0;
    endcase
  endfunction

  // Pulse length for a length select; 0 for the held mode
  function automatic int unsigned len_cycles(input len_e len, input int unsigned n_short,
                                             input int unsigned n_mid, input int unsigned n_long);
    case (len)
      LEN_SHORT: return n_short;
      LEN_MID:   return n_mid;
      LEN_LONG:  return n_long;
      default:   return 0;
    endcase
  endfunction

  // Next sticky status: an event beats a clear of the same bit
  function automatic logic [NUM_SRC-1:0] sticky_next(input logic [NUM_SRC-1:0] cur,
                                                     input logic [NUM_SRC-1:0] set,
                                                     input logic [NUM_SRC-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/vid_irq_regs.sv
module vid_irq_regs
  import vid_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h42,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h43,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h44
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic [NUM_SRC-1:0]  status,
  output cfg_t                cfg,
  output logic [NUM_SRC-1:0]  mask,
  output logic [NUM_SRC-1:0]  clr,
  output logic [7:0]          rdata
);

  localparam logic [7:0] CFG_KEEP = 8'hF7;

  logic wr_cfg, wr_clr, wr_mask;

  assign wr_cfg  = wr_en && (addr == CFG_OFS);
  assign wr_clr  = wr_en && (addr == CLR_OFS);
  assign wr_mask = wr_en && (addr == MASK_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      mask <= '0;
    end else begin
      if (wr_cfg)  cfg  <= cfg_t'(wdata & CFG_KEEP);
      if (wr_mask) mask <= wdata[NUM_SRC-1:0];
    end
  end

  // clear strobe lasts only for the write cycle; upper bits dropped
  assign clr = wr_clr ? wdata[NUM_SRC-1:0] : '0;

  always_comb begin
    rdata = '0;
    if (addr == CFG_OFS)       rdata = cfg;
    else if (addr == STAT_OFS) rdata[NUM_SRC-1:0] = status;
    else if (addr == MASK_OFS) rdata[NUM_SRC-1:0] = mask;
  end

endmodule

// File: rtl/vid_irq_status.sv
module vid_irq_status
  import vid_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_lock,
  input  logic                ev_unlock,
  input  logic                ev_freerun,
  input  logic                ev_cp,
  input  logic                cp_pseudo,
  input  logic                cp_stripe,
  input  logic [1:0]          cp_sel,
  input  logic                manual,
  input  logic [NUM_SRC-1:0]  clr,
  input  logic [NUM_SRC-1:0]  mask,
  output logic [NUM_SRC-1:0]  set_bits,
  output logic [NUM_SRC-1:0]  hit,
  output logic [NUM_SRC-1:0]  status,
  output logic                req
);

  logic cp_ok;

  assign cp_ok = ev_cp & cp_qualify(cp_sel, cp_pseudo, cp_stripe);

  always_comb begin
    set_bits = '0;
    set_bits[SRC_LOCK]    = ev_lock;
    set_bits[SRC_UNLOCK]  = ev_unlock;
    set_bits[SRC_FREERUN] = ev_freerun;
    set_bits[SRC_CP]      = cp_ok;
  end

  assign hit = set_bits & ~mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= sticky_next(status, set_bits, clr);
  end

  assign req = (|(status & ~mask)) | manual;

endmodule

// File: rtl/vid_irq_pulse.sv
module vid_irq_pulse
  import vid_irq_pkg::*;
#(
  parameter int unsigned SHORT_LEN = 3,
  parameter int unsigned MID_LEN = 15,
  parameter int unsigned LONG_LEN = 63
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic [NUM_SRC-1:0]  hit,
  input  len_e                len,
  input  drv_e                drive,
  output logic                trig,
  output logic                active,
  output logic                pad_o,
  output logic                pad_oe
);

  localparam int CNT_W = $clog2(LONG_LEN + 1);

  logic             req_q;
  logic             hit_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(len_cycles(len, SHORT_LEN, MID_LEN, LONG_LEN));
  assign trig     = (req & ~req_q) | hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      hit_q <= 1'b0;
      cnt   <= '0;
    end else begin
      req_q <= req;
      hit_q <= |hit;
      if (trig)          cnt <= load_val;
      else if (cnt != 0) cnt <= cnt - 1'b1;
    end
  end

  assign active = (len == LEN_HOLD) ? req : (cnt != 0);

  always_comb begin
    case (drive)
      DRV_OPEN: begin pad_oe = active; pad_o = 1'b0;    end
      DRV_LOW:  begin pad_oe = 1'b1;   pad_o = ~active; end
      DRV_HIGH: begin pad_oe = 1'b1;   pad_o = active;  end
      default:  begin pad_oe = 1'b0;   pad_o = 1'b0;    end
    endcase
  end

endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
  import vid_irq_pkg::*;
#(
  parameter int unsigned SHORT_LEN = 3,
  parameter int unsigned MID_LEN = 15,
  parameter int unsigned LONG_LEN = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ev_lock,
  input  logic       ev_unlock,
  input  logic       ev_freerun,
  input  logic       ev_cp,
  input  logic       cp_pseudo,
  input  logic       cp_stripe,
  output logic       irq_o,
  output logic       irq_oe
);

  cfg_t               cfg;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] clr_bits;
  logic [NUM_SRC-1:0] set_bits;
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] status;
  logic               req;
  logic               trig;
  logic               pulse_active;

  vid_irq_regs #(.ADDR_W(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .status(status), .cfg(cfg), .mask(mask),
    .clr(clr_bits), .rdata(reg_rdata)
  );

  vid_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .ev_lock(ev_lock), .ev_unlock(ev_unlock),
    .ev_freerun(ev_freerun), .ev_cp(ev_cp), .cp_pseudo(cp_pseudo),
    .cp_stripe(cp_stripe), .cp_sel(cfg.cp_sel), .manual(cfg.manual),
    .clr(clr_bits), .mask(mask), .set_bits(set_bits), .hit(hit),
    .status(status), .req(req)
  );

  vid_irq_pulse #(.SHORT_LEN(SHORT_LEN), .MID_LEN(MID_LEN), .LONG_LEN(LONG_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .req(req), .hit(hit), .len(cfg.len),
    .drive(cfg.drive), .trig(trig), .active(pulse_active),
    .pad_o(irq_o), .pad_oe(irq_oe)
  );

endmodule

// File: rtl/vid_irq_chk.sv
module vid_irq_chk
  import vid_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] set_bits,
  input logic [NUM_SRC-1:0] clr_bits,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] mask,
  input logic               req,
  input logic               trig,
  input logic               pulse_active,
  input logic [1:0]         drive,
  input logic [1:0]         len,
  input logic               manual,
  input logic               irq_o,
  input logic               irq_oe
);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_bits & ~set_bits) != 0) |=> ((status & $past(clr_bits & ~set_bits)) == 0));

  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != 0) |=> ((status & $past(set_bits)) == $past(set_bits)));

  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mask) && !manual && len == 2'b11) |-> !pulse_active);

  p_trig_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && len != 2'b11) |=> pulse_active);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (len == 2'b11 && !req) |-> !pulse_active);

  p_open_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (drive == 2'b00) |-> (!irq_o && irq_oe == pulse_active));

  p_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (drive == 2'b11) |-> (!irq_oe && !irq_o));

  p_manual_r11: assert property (@(posedge clk) disable iff (!rst_n)
    manual |-> req);

endmodule

bind vid_irq_ctrl vid_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .clr_bits(clr_bits),
  .status(status), .mask(mask), .req(req), .trig(trig),
  .pulse_active(pulse_active), .drive(cfg.drive), .len(cfg.len),
  .manual(cfg.manual), .irq_o(irq_o), .irq_oe(irq_oe)
);

// File: tb/vid_irq_ctrl_tb.sv
module vid_irq_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ev_lock = 1'b0, ev_unlock = 1'b0, ev_freerun = 1'b0, ev_cp = 1'b0;
  logic       cp_pseudo = 1'b0, cp_stripe = 1'b0;
  logic       irq_o, irq_oe;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 0;

  // {cp_sel[1:0], pseudo, stripe, expected status bit 3} for R3
  localparam logic [4:0] CP_VEC [8] = '{
    5'b00_11_0, 5'b01_10_1, 5'b01_01_0, 5'b10_10_0,
    5'b10_01_1, 5'b11_10_1, 5'b11_01_1, 5'b11_00_0
  };

  vid_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_lock(ev_lock),
    .ev_unlock(ev_unlock), .ev_freerun(ev_freerun), .ev_cp(ev_cp),
    .cp_pseudo(cp_pseudo), .cp_stripe(cp_stripe), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mk_cfg(input logic [1:0] len, input logic [1:0] sel,
                                        input logic man, input logic [1:0] drv);
    return {len, sel, 1'b0, man, drv};
  endfunction

  task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // pulse one event input (0 lock, 1 unlock, 2 freerun, 3 cp) for one cycle
  task automatic pulse_ev(input int which, input logic ps, input logic st);
    @(negedge clk);
    case (which)
      0: ev_lock = 1'b1;
      1: ev_unlock = 1'b1;
      2: ev_freerun = 1'b1;
      default: begin ev_cp = 1'b1; cp_pseudo = ps; cp_stripe = st; end
    endcase
    @(negedge clk);
    ev_lock = 0; ev_unlock = 0; ev_freerun = 0; ev_cp = 0; cp_pseudo = 0; cp_stripe = 0;
  endtask

  // count cycles irq_o is high (drive mode active-high) after a lock event
  task automatic measure(input bit retrig, output int len_seen);
    int cnt = 0;
    pulse_ev(0, 0, 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      ev_unlock = 1'b0;
      if (irq_o) begin
        cnt++;
        if (retrig && cnt == 1) ev_unlock = 1'b1;
      end else if (cnt > 0) break;
    end
    len_seen = cnt;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int lenv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h40, d); check("R1 cfg", d, 8'h00);
    rd(8'h42, d); check("R1 status", d, 8'h00);
    rd(8'h44, d); check("R1 mask", d, 8'h00);
    check("R1 pad", {6'd0, irq_oe, irq_o}, 8'h00);

    // R3/R8 table: held mode, active-high pad
    foreach (CP_VEC[k]) begin
      wr(8'h40, mk_cfg(2'b11, CP_VEC[k][4:3], 1'b0, 2'b10));
      wr(8'h43, 8'h0F);
      pulse_ev(3, CP_VEC[k][2], CP_VEC[k][1]);
      rd(8'h42, d); check("R3 cp status", d, {7'd0, CP_VEC[k][0]} << 3);
      check("R8 held pad", {7'd0, irq_o}, {7'd0, CP_VEC[k][0]});
    end
    wr(8'h43, 8'h0F);
    check("R8 held drop", {7'd0, irq_o}, 8'h00);

    // R2 sticky capture
    pulse_ev(0, 0, 0); rd(8'h42, d); check("R2 lock", d, 8'h01);
    pulse_ev(1, 0, 0); rd(8'h42, d); check("R2 unlock", d, 8'h03);
    pulse_ev(2, 0, 0); rd(8'h42, d); check("R2 freerun", d, 8'h07);

    // R4 clear semantics
    wr(8'h43, 8'hF0); rd(8'h42, d); check("R4 reserved clear", d, 8'h07);
    wr(8'h43, 8'h02); rd(8'h42, d); check("R4 clear one", d, 8'h05);
    rd(8'h43, d); check("R4 clear reads 0", d, 8'h00);
    wr(8'h43, 8'h0F); rd(8'h42, d); check("R4 clear all", d, 8'h00);

    // R5 event beats clear
    @(negedge clk);
    ev_lock = 1'b1; reg_wr_en = 1'b1; reg_addr = 8'h43; reg_wdata = 8'h01;
    @(negedge clk);
    ev_lock = 1'b0; reg_wr_en = 1'b0;
    rd(8'h42, d); check("R5 event wins", d, 8'h01);
    wr(8'h43, 8'h0F);

    // R6 mask
    wr(8'h44, 8'h01);
    pulse_ev(0, 0, 0);
    rd(8'h42, d); check("R6 masked status kept", d, 8'h01);
    check("R6 masked pad", {7'd0, irq_o}, 8'h00);
    wr(8'h44, 8'h00);
    check("R6 unmasked pad", {7'd0, irq_o}, 8'h01);

    // R10 pad styles with request active
    wr(8'h40, mk_cfg(2'b11, 2'b00, 1'b0, 2'b00)); check("R10 od active", {6'd0, irq_oe, irq_o}, 8'h02);
    wr(8'h40, mk_cfg(2'b11, 2'b00, 1'b0, 2'b01)); check("R10 low active", {6'd0, irq_oe, irq_o}, 8'h02);
    wr(8'h40, mk_cfg(2'b11, 2'b00, 1'b0, 2'b10)); check("R10 high active", {6'd0, irq_oe, irq_o}, 8'h03);
    wr(8'h40, mk_cfg(2'b11, 2'b00, 1'b0, 2'b11)); check("R10 reserved", {6'd0, irq_oe, irq_o}, 8'h00);
    wr(8'h43, 8'h0F);
    wr(8'h40, mk_cfg(2'b11, 2'b00, 1'b0, 2'b00)); check("R10 od idle", {6'd0, irq_oe, irq_o}, 8'h00);
    wr(8'h40, mk_cfg(2'b11, 2'b00, 1'b0, 2'b01)); check("R10 low idle", {6'd0, irq_oe, irq_o}, 8'h03);

    // R11 manual force
    wr(8'h40, mk_cfg(2'b11, 2'b00, 1'b1, 2'b10));
    check("R11 manual on", {7'd0, irq_o}, 8'h01);
    rd(8'h42, d); check("R11 status untouched", d, 8'h00);
    wr(8'h40, mk_cfg(2'b11, 2'b00, 1'b0, 2'b10));
    check("R11 manual off", {7'd0, irq_o}, 8'h00);

    // R7 fixed lengths
    wr(8'h40, mk_cfg(2'b00, 2'b00, 1'b0, 2'b10)); measure(0, lenv); check("R7 len 3", 8'(lenv), 8'd3);
    wr(8'h43, 8'h0F);
    wr(8'h40, mk_cfg(2'b01, 2'b00, 1'b0, 2'b10)); measure(0, lenv); check("R7 len 15", 8'(lenv), 8'd15);
    wr(8'h43, 8'h0F);
    wr(8'h40, mk_cfg(2'b10, 2'b00, 1'b0, 2'b10)); measure(0, lenv); check("R7 len 63", 8'(lenv), 8'd63);
    wr(8'h43, 8'h0F);

    // R9 retrigger: event in first active cycle extends 3 to 5
    wr(8'h40, mk_cfg(2'b00, 2'b00, 1'b0, 2'b10)); measure(1, lenv); check("R9 retrigger", 8'(lenv), 8'd5);
    wr(8'h43, 8'h0F);

    // R12 reserved and unmapped reads
    wr(8'h40, 8'hFF); rd(8'h40, d); check("R12 cfg rsvd", d, 8'hF7);
    wr(8'h44, 8'hFF); rd(8'h44, d); check("R12 mask upper", d, 8'h0F);
    rd(8'h41, d); check("R12 unmapped 41", d, 8'h00);
    rd(8'h55, d); check("R12 unmapped 55", d, 8'h00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule